// File: doc/BRIEF.md
# Low-Speed Crystal Clock Failure Monitor

This block watches a slow external crystal clock (nominally 32 kHz) that feeds a real-time clock. It samples that clock in the domain of an internal low-speed reference oscillator. Software arms the monitor with a set-only strobe. The strobe is honoured only when both oscillators are switched on and report ready, and a real-time-clock source has already been selected. Once armed, the monitor counts reference cycles between transitions of the synchronized crystal clock. When the gap grows too long, it declares a failure.

On a failure, the monitor disarms itself and latches a sticky failure flag. It closes a glitch-free gate so that the crystal clock no longer reaches the real-time-clock clock output, and it sends a one-cycle request that takes an auxiliary oscillator out of its crystal-locked mode. No configuration input is changed. Recovery is left to software. In standby the flag appears as a wakeup request. In any other mode it raises an interrupt, provided the interrupt enable is set.

The monitor state survives a system reset. Only a power-on reset or a real-time-clock domain software reset clears it. The reference period and `TIMEOUT_CYC` must be chosen so that a healthy crystal clock above 30 kHz always toggles within the window.

Top module: `lsclk_fail_mon`

## Requirements
- R1: A pulse on `sw_mon_set` sets `mon_en_o` only when `xtal_on`, `xtal_rdy`, `ref_on` and `ref_rdy` are all 1 and `rtc_src` is not 2'b00 (2'b00 means no source selected). Otherwise the pulse is ignored and `mon_en_o` stays 0.
- R2: Once set, `mon_en_o` is cleared only by `por_n` low, by `rtc_sw_rst` high, or by a detected failure. A `rtc_sw_rst` pulse also clears `fail_flag_o`.
- R3: While `mon_en_o` is 1, a failure is declared when `TIMEOUT_CYC` consecutive `clk` cycles pass with no synchronized transition of `mon_clk`. The failure sets `fail_flag_o` and clears `mon_en_o` on the same edge.
- R4: A `mon_clk` whose synchronized transitions are never more than `TIMEOUT_CYC` cycles apart never causes a failure.
- R5: Each failure produces exactly one single-cycle pulse on `pll_mode_drop_o`, asserted together with `fail_flag_o`.
- R6: `rtc_clk_o` follows `mon_clk` until a failure. It then stays low until `por_n`, `rtc_sw_rst` or an accepted `sw_mon_set` reopens it, and it is never high while `mon_clk` is low.
- R7: `fail_flag_o` is sticky and is cleared by a `sw_flag_clr` pulse. A failure detected in the same cycle as a clear wins.
- R8: With `standby_i` = 1, `wakeup_o` equals `fail_flag_o` and `irq_o` is 0. With `standby_i` = 0, `irq_o` = `fail_flag_o` AND `irq_en_o`, and `wakeup_o` is 0.
- R9: `irq_en_o` is loaded from `sw_irq_en_d` by `sw_irq_en_wr`. `sys_rst_n` low clears `irq_en_o` and leaves `mon_en_o` and `fail_flag_o` unchanged. `por_n` low clears every state bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock; all state is clocked here |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| sys_rst_n | input | 1 | System reset, synchronous, active low; clears only the interrupt enable |
| rtc_sw_rst | input | 1 | Real-time-clock domain software reset, synchronous, active high |
| mon_clk | input | 1 | Monitored external crystal clock |
| xtal_on | input | 1 | External crystal oscillator enabled |
| xtal_rdy | input | 1 | External crystal oscillator ready |
| ref_on | input | 1 | Reference oscillator enabled |
| ref_rdy | input | 1 | Reference oscillator ready |
| rtc_src | input | 2 | Real-time-clock source select; 2'b00 = none |
| standby_i | input | 1 | Chip is in standby mode |
| sw_mon_set | input | 1 | Software strobe that arms the monitor |
| sw_flag_clr | input | 1 | Software strobe that clears the failure flag |
| sw_irq_en_wr | input | 1 | Software strobe that writes the interrupt enable |
| sw_irq_en_d | input | 1 | Interrupt enable value to write |
| mon_en_o | output | 1 | Monitor armed (readback) |
| fail_flag_o | output | 1 | Sticky failure flag |
| irq_en_o | output | 1 | Interrupt enable (readback) |
| irq_o | output | 1 | Failure interrupt request |
| wakeup_o | output | 1 | Failure wakeup request in standby |
| pll_mode_drop_o | output | 1 | One-cycle request to leave the crystal-locked mode |
| rtc_clk_o | output | 1 | Gated crystal clock for the real-time clock |

## Verification
The bench builds the block with `TIMEOUT_CYC` = 6 and `SYNC_STAGES` = 2 and clocks `mon_clk` with half-periods that are whole multiples of the reference clock. A half-period of 6 cycles is therefore the longest gap that must pass, and 7 cycles is the shortest that must fail, so both sides of the R3/R4 window are exercised exactly. At this small window a stopped crystal clock is flagged within a few dozen cycles. That leaves room to cover re-arming, the gate closing and reopening, interrupt versus wakeup routing and each reset source in one short run.

// File: rtl/lsmon_pkg.sv
// Shared definitions for the low-speed crystal clock failure monitor.
// Assumes the real-time-clock source select uses code 2'b00 for "none".
package lsmon_pkg;

    typedef enum logic [1:0] {
        RTC_SRC_NONE = 2'b00,
        RTC_SRC_XTAL = 2'b01,
        RTC_SRC_REF  = 2'b10,
        RTC_SRC_HS   = 2'b11
    } rtc_src_e;

    // Returns 1 when every arming precondition holds.
    function automatic logic arm_allowed(input logic xon, input logic xrdy,
                                         input logic ron, input logic rrdy,
                                         input logic [1:0] src);
        return xon && xrdy && ron && rrdy && (src != RTC_SRC_NONE);
    endfunction

endpackage

// File: rtl/lsmon_edge_sync.sv
// Synchronizes the monitored clock into the reference domain and flags
// every transition (rising or falling) of the synchronized level.
// Assumes the monitored clock is slower than the reference clock.
module lsmon_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic edge_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] shift_q;

    // Synchronizer chain plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[SH_W-2:0], async_i};
    end

    assign edge_o = shift_q[SH_W-1] ^ shift_q[SH_W-2];

endmodule

// File: rtl/lsmon_timeout.sv
// Counts reference cycles since the last monitored transition and signals
// expiry when TIMEOUT_CYC cycles pass with no transition while armed.
// Assumes clr_i is held while the monitor is disarmed.
module lsmon_timeout #(
    parameter int TIMEOUT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic edge_i,
    output logic expire_o
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(TIMEOUT_CYC);

    logic [CNT_W-1:0] cnt_q;

    // Gap counter, restarted by each transition, saturating at the window.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || edge_i) cnt_q <= '0;
        else if (cnt_q != FULL)        cnt_q <= cnt_q + 1'b1;
    end

    assign expire_o = !clr_i && !edge_i && (cnt_q == LAST);

endmodule

// File: rtl/lsmon_clk_gate.sv
// Glitch-free clock gate: the enable is captured by a latch that is
// transparent only while the gated clock is low.
// Assumes en_i changes at most once per gated-clock low phase.
module lsmon_clk_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic clk_o
);
    logic en_lat;

    // Enable latch, open during the low phase of the gated clock.
    always_latch begin
        if (!clk_i) en_lat = en_i;
    end

    assign clk_o = clk_i & en_lat;

endmodule

// File: rtl/lsclk_fail_mon.sv
// Top of the low-speed crystal clock failure monitor. Holds the arming,
// failure and interrupt-enable state, routes the flag to interrupt or
// wakeup and gates the real-time-clock output after a failure.
// Assumes all software strobes are synchronous to clk.
module lsclk_fail_mon #(
    parameter int TIMEOUT_CYC = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       sys_rst_n,
    input  logic       rtc_sw_rst,
    input  logic       mon_clk,
    input  logic       xtal_on,
    input  logic       xtal_rdy,
    input  logic       ref_on,
    input  logic       ref_rdy,
    input  logic [1:0] rtc_src,
    input  logic       standby_i,
    input  logic       sw_mon_set,
    input  logic       sw_flag_clr,
    input  logic       sw_irq_en_wr,
    input  logic       sw_irq_en_d,
    output logic       mon_en_o,
    output logic       fail_flag_o,
    output logic       irq_en_o,
    output logic       irq_o,
    output logic       wakeup_o,
    output logic       pll_mode_drop_o,
    output logic       rtc_clk_o
);
    import lsmon_pkg::*;

    logic mon_en_q, failed_q, flag_q, drop_q, irq_en_q;
    logic mon_edge, fail_now, arm_ok;

    lsmon_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (por_n),
        .async_i(mon_clk),
        .edge_o (mon_edge)
    );

    lsmon_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
        .clk     (clk),
        .rst_n   (por_n),
        .clr_i   (!mon_en_q || rtc_sw_rst),
        .edge_i  (mon_edge),
        .expire_o(fail_now)
    );

    lsmon_clk_gate u_gate (
        .clk_i(mon_clk),
        .en_i (!failed_q),
        .clk_o(rtc_clk_o)
    );

    assign arm_ok = sw_mon_set && arm_allowed(xtal_on, xtal_rdy, ref_on, ref_rdy, rtc_src);

    // Arming and failure state; survives system reset.
    always_ff @(posedge clk) begin
        if (!por_n || rtc_sw_rst) begin
            mon_en_q <= 1'b0;
            failed_q <= 1'b0;
            drop_q   <= 1'b0;
        end else begin
            drop_q <= fail_now;
            if (fail_now) begin
                mon_en_q <= 1'b0;
                failed_q <= 1'b1;
            end else if (arm_ok) begin
                mon_en_q <= 1'b1;
                failed_q <= 1'b0;
            end
        end
    end

    // Sticky failure flag; detection wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!por_n || rtc_sw_rst) flag_q <= 1'b0;
        else if (fail_now)        flag_q <= 1'b1;
        else if (sw_flag_clr)     flag_q <= 1'b0;
    end

    // Interrupt enable, held in the system reset domain.
    always_ff @(posedge clk) begin
        if (!por_n || !sys_rst_n) irq_en_q <= 1'b0;
        else if (sw_irq_en_wr)    irq_en_q <= sw_irq_en_d;
    end

    assign mon_en_o        = mon_en_q;
    assign fail_flag_o     = flag_q;
    assign irq_en_o        = irq_en_q;
    assign pll_mode_drop_o = drop_q;
    assign wakeup_o        = flag_q && standby_i;
    assign irq_o           = flag_q && irq_en_q && !standby_i;

endmodule

// File: rtl/lsclk_fail_mon_chk.sv
// Property checker for lsclk_fail_mon, attached through bind below.
// Assumes the ports carry the same names as those of the monitored top.
module lsclk_fail_mon_chk (
    input logic       clk,
    input logic       por_n,
    input logic       sys_rst_n,
    input logic       rtc_sw_rst,
    input logic       mon_clk,
    input logic       xtal_on,
    input logic       xtal_rdy,
    input logic       ref_on,
    input logic       ref_rdy,
    input logic [1:0] rtc_src,
    input logic       standby_i,
    input logic       sw_mon_set,
    input logic       sw_flag_clr,
    input logic       mon_en_o,
    input logic       fail_flag_o,
    input logic       irq_en_o,
    input logic       irq_o,
    input logic       wakeup_o,
    input logic       pll_mode_drop_o,
    input logic       rtc_clk_o
);
    logic pre_ok;
    assign pre_ok = xtal_on && xtal_rdy && ref_on && ref_rdy && (rtc_src != 2'b00);

    AST_ARM_NEEDS_PRECOND: assert property (@(posedge clk) disable iff (!por_n)
        $rose(mon_en_o) |-> $past(sw_mon_set && pre_ok)); // R1

    AST_DOMRST_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        $past(rtc_sw_rst) |-> (!mon_en_o && !fail_flag_o)); // R2

    AST_FAIL_DISARMS: assert property (@(posedge clk) disable iff (!por_n)
        pll_mode_drop_o |-> (fail_flag_o && !mon_en_o)); // R3

    AST_DROP_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        pll_mode_drop_o |=> !pll_mode_drop_o); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (fail_flag_o && !sw_flag_clr && !rtc_sw_rst) |=> fail_flag_o); // R7

    AST_WAKE_STANDBY_ONLY: assert property (@(posedge clk) disable iff (!por_n)
        wakeup_o |-> (standby_i && fail_flag_o && !irq_o)); // R8

    AST_IRQ_RUN_ONLY: assert property (@(posedge clk) disable iff (!por_n)
        irq_o |-> (!standby_i && irq_en_o && fail_flag_o)); // R8

    AST_SYSRST_IRQEN: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n && !rtc_sw_rst) |=> (!irq_en_o && (fail_flag_o == $past(fail_flag_o)))); // R9

    // Gated output never high while the source clock is low.
    always_comb begin
        if (por_n === 1'b1)
            AST_GATE_NO_GLITCH: assert (!(rtc_clk_o === 1'b1 && mon_clk === 1'b0)); // R6
    end

endmodule

bind lsclk_fail_mon lsclk_fail_mon_chk u_chk (
    .clk            (clk),
    .por_n          (por_n),
    .sys_rst_n      (sys_rst_n),
    .rtc_sw_rst     (rtc_sw_rst),
    .mon_clk        (mon_clk),
    .xtal_on        (xtal_on),
    .xtal_rdy       (xtal_rdy),
    .ref_on         (ref_on),
    .ref_rdy        (ref_rdy),
    .rtc_src        (rtc_src),
    .standby_i      (standby_i),
    .sw_mon_set     (sw_mon_set),
    .sw_flag_clr    (sw_flag_clr),
    .mon_en_o       (mon_en_o),
    .fail_flag_o    (fail_flag_o),
    .irq_en_o       (irq_en_o),
    .irq_o          (irq_o),
    .wakeup_o       (wakeup_o),
    .pll_mode_drop_o(pll_mode_drop_o),
    .rtc_clk_o      (rtc_clk_o)
);

// File: tb/lsclk_fail_mon_tb.sv
// Directed bench for lsclk_fail_mon: one task per scenario.
module lsclk_fail_mon_tb;

    localparam int TMO = 6;

    logic clk = 1'b0;
    logic por_n = 1'b0, sys_rst_n = 1'b0, rtc_sw_rst = 1'b0;
    logic mon_clk = 1'b0;
    logic xtal_on = 1'b1, xtal_rdy = 1'b1, ref_on = 1'b1, ref_rdy = 1'b1;
    logic [1:0] rtc_src = 2'b01;
    logic standby_i = 1'b0;
    logic sw_mon_set = 1'b0, sw_flag_clr = 1'b0, sw_irq_en_wr = 1'b0, sw_irq_en_d = 1'b0;
    logic mon_en_o, fail_flag_o, irq_en_o, irq_o, wakeup_o, pll_mode_drop_o, rtc_clk_o;

    int n_chk = 0, n_bad = 0;
    int mon_half = 2, mon_cnt = 0;
    int rtc_edges = 0, drop_cnt = 0;

    lsclk_fail_mon #(.TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) u_dut (.*);

    always #2 clk = ~clk;

    // Monitored clock: toggles every mon_half reference cycles, 0 = stopped.
    always @(negedge clk) begin
        if (mon_half != 0) begin
            if (mon_cnt + 1 >= mon_half) begin
                mon_clk <= ~mon_clk;
                mon_cnt <= 0;
            end else mon_cnt <= mon_cnt + 1;
        end
    end

    always @(posedge rtc_clk_o) rtc_edges++;
    always @(posedge clk) if (pll_mode_drop_o === 1'b1) drop_cnt++;

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_set();
        sw_mon_set = 1'b1; cyc(1); sw_mon_set = 1'b0; cyc(1);
    endtask

    task automatic t_reset();
        cyc(5); por_n = 1'b1; sys_rst_n = 1'b1; cyc(2);
        check("R9 por clears mon_en", mon_en_o, 0);
        check("R9 por clears flag", fail_flag_o, 0);
        check("R9 por clears irq_en", irq_en_o, 0);
        check("R8 no irq/wakeup after reset", irq_o | wakeup_o, 0);
    endtask

    task automatic t_precond();
        xtal_rdy = 1'b0; pulse_set();
        check("R1 set ignored, xtal not ready", mon_en_o, 0);
        xtal_rdy = 1'b1; ref_on = 1'b0; pulse_set();
        check("R1 set ignored, ref off", mon_en_o, 0);
        ref_on = 1'b1; rtc_src = 2'b00; pulse_set();
        check("R1 set ignored, no rtc source", mon_en_o, 0);
        rtc_src = 2'b01; pulse_set();
        check("R1 set accepted", mon_en_o, 1);
    endtask

    task automatic t_healthy();
        mon_half = 2; rtc_edges = 0; cyc(150);
        check("R4 fast clock no failure", fail_flag_o, 0);
        check("R4 still armed", mon_en_o, 1);
        check("R6 clock forwarded", int'(rtc_edges > 10), 1);
        mon_half = 6; cyc(200);
        check("R4 gap of TIMEOUT cycles no failure", fail_flag_o, 0);
    endtask

    task automatic t_fail();
        drop_cnt = 0; mon_half = 7; cyc(40);
        check("R3 gap above window fails", fail_flag_o, 1);
        check("R3 failure disarms", mon_en_o, 0);
        check("R5 one drop pulse", drop_cnt, 1);
        mon_half = 2; cyc(4); rtc_edges = 0; cyc(60);
        check("R6 output gated after failure", rtc_edges, 0);
        check("R7 flag sticky", fail_flag_o, 1);
        sw_flag_clr = 1'b1; cyc(1); sw_flag_clr = 1'b0; cyc(1);
        check("R7 clear strobe", fail_flag_o, 0);
        cyc(30);
        check("R2 no rearm without write", mon_en_o, 0);
    endtask

    task automatic t_modes();
        pulse_set(); cyc(4); rtc_edges = 0; cyc(40);
        check("R6 gate reopened by rearm", int'(rtc_edges > 5), 1);
        mon_half = 0; cyc(30);
        check("R3 stopped clock fails", fail_flag_o, 1);
        check("R8 irq off when disabled", irq_o, 0);
        sw_irq_en_d = 1'b1; sw_irq_en_wr = 1'b1; cyc(1); sw_irq_en_wr = 1'b0; cyc(1);
        check("R9 irq_en written", irq_en_o, 1);
        check("R8 irq when enabled", irq_o, 1);
        check("R8 no wakeup outside standby", wakeup_o, 0);
        standby_i = 1'b1; cyc(1);
        check("R8 wakeup in standby", wakeup_o, 1);
        check("R8 irq off in standby", irq_o, 0);
        standby_i = 1'b0; cyc(1);
    endtask

    task automatic t_resets();
        sys_rst_n = 1'b0; cyc(1); sys_rst_n = 1'b1; cyc(1);
        check("R9 sys reset clears irq_en", irq_en_o, 0);
        check("R9 sys reset keeps flag", fail_flag_o, 1);
        mon_half = 2; cyc(4);
        sw_flag_clr = 1'b1; cyc(1); sw_flag_clr = 1'b0;
        pulse_set(); cyc(10);
        sys_rst_n = 1'b0; cyc(1); sys_rst_n = 1'b1; cyc(3);
        check("R9 sys reset keeps mon_en", mon_en_o, 1);
        rtc_sw_rst = 1'b1; cyc(1); rtc_sw_rst = 1'b0; cyc(1);
        check("R2 domain reset clears mon_en", mon_en_o, 0);
        mon_half = 0; cyc(30);
        check("R2 disarmed monitor does not flag", fail_flag_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_precond();
        t_healthy();
        t_fail();
        t_modes();
        t_resets();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule